// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Streamer

This block holds a configuration bit stream in an internal bit array and hands it out one bit per configuration clock to the serial data input of a programmable logic device. A bit address counter walks through the array. It advances only while the combined reset/output-enable control is at its enable level, chip select is low and bits remain to be sent. The data pin is modelled as a value plus an output-enable, so that several devices can share one line.

When the last stored bit has been delivered, the next clock edge marks the device as exhausted. The active-low cascade output then falls and the data line is released. Wiring that cascade output to the chip select of a second instance lets the second device continue the stream with no gap and no overlap.

The reset/output-enable control has a stored polarity bit, so either level can mean reset. Each time the reset level is seen, the device also records whether it is the head of a chain. The array is filled through a one-bit parallel write port before streaming starts.

Top module: `cfg_bit_streamer`

## Requirements
- R1: While enabled (enable level on `rst_oe`, `cs_n` low, not exhausted), each rising clock edge advances the bit address by one, and `data_o` then shows the stored bit at the new address. Bit index 0 is presented first.
- R2: The address holds its value on every edge where any of the three enable conditions is missing and the reset level is not applied. A stream interrupted by chip select resumes at the bit where it stopped.
- R3: While the reset level is applied to `rst_oe`, `data_oe` is low in the same cycle whatever `cs_n` is, and the address is zero after the next edge.
- R4: While `cs_n` is high the device is in standby: `data_oe` is low and the address is frozen. When `cs_n` falls, `data_oe` rises in the same cycle and the bit at the held address is driven.
- R5: The clock edge after the last bit (index DEPTH_BITS-1) has been presented drives `cascade_n` low and `data_oe` low. Both stay low, without wrapping the address, until the reset level is applied.
- R6: The polarity bit is written with `pol_wr_en`/`pol_wr_val` and takes effect from the next cycle. Value 0 (the value after `rst_n`) makes `rst_oe` low the reset level and high the enable level. Value 1 swaps the two levels.
- R7: Asynchronous `rst_n` low clears the address (`cascade_n` high), sets the polarity bit to 0 and clears `chain_first`. Its release is synchronised to the clock.
- R8: On every edge where the reset level is applied, `chain_first` takes the inverse of `cs_n`: 1 marks the head of a chain, 0 a later device. On other edges it holds.
- R9: A high `wr_en` at a clock edge stores `wr_bit` at index `wr_addr`. The stored bit is the one streamed at that index.
- R10: With the first device's `cascade_n` tied to the second device's `cs_n`, the two data enables are never high together, and the data line carries both arrays back to back without a missing or repeated bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; rising edges advance the stream |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| rst_oe | input | 1 | Combined reset / output-enable control, polarity programmable |
| cs_n | input | 1 | Active-low chip select |
| pol_wr_en | input | 1 | Strobe that loads the polarity bit |
| pol_wr_val | input | 1 | New polarity value (0: low means reset) |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | $clog2(DEPTH_BITS) | Array write index |
| wr_bit | input | 1 | Bit value to store |
| data_o | output | 1 | Serial data value |
| data_oe | output | 1 | Drive enable for the data value (low means high impedance) |
| cascade_n | output | 1 | Active-low hand-off to the next device in a chain |
| chain_first | output | 1 | Set when the device was reset with chip select low |

## Verification
The hand-off is the point where two functions meet in one clock edge. The same edge that retires the first device's last bit lowers its cascade output, and with it the second device's chip select. In that cycle the second device must start driving its bit 0 while the first device releases the line. The bench chains two instances and streams both arrays in one run, once without a break and once with a chip-select pause in the middle. A scoreboard queue holds the concatenated expected stream. At every falling edge it checks that at most one enable is high and that the driven bit is the next one in the queue, so a gap, an overlap or a repeated bit at the seam is reported.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  // decoded meaning of the combined reset / output-enable control
  typedef struct packed {
    logic rst_hit;  // reset level present
    logic oe_hit;   // enable level present
  } ctl_t;

  // pol = 0: low level resets, high level enables; pol = 1: swapped
  function automatic ctl_t decode_ctl(input logic pol, input logic pin);
    ctl_t c;
    c.rst_hit = pol ? pin : ~pin;
    c.oe_hit  = ~c.rst_hit;
    return c;
  endfunction

endpackage

// File: rtl/cfg_ctrl_decode.sv
module cfg_ctrl_decode
  import cfg_stream_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_oe,
  input  logic cs_n,
  input  logic pol_wr_en,
  input  logic pol_wr_val,
  output ctl_t ctl,
  output logic chain_first
);

  logic pol_q, pol_d, pol_en;
  logic first_q, first_d, first_en;

  // control meaning follows the stored polarity
  assign ctl = decode_ctl(pol_q, rst_oe);

  always_comb begin
    pol_en   = pol_wr_en;
    pol_d    = pol_wr_val;
    // head-of-chain flag is sampled whenever the reset level is seen
    first_en = ctl.rst_hit;
    first_d  = ~cs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (pol_en)   pol_q   <= pol_d;
      if (first_en) first_q <= first_d;
    end
  end

  assign chain_first = first_q;

endmodule

// File: rtl/cfg_addr_counter.sv
module cfg_addr_counter #(
  parameter int DEPTH_BITS = 64,
  parameter int AW         = $clog2(DEPTH_BITS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] addr_q,
  output logic          exhausted
);

  localparam logic [AW-1:0] END_ADDR = AW'(DEPTH_BITS);

  logic [AW-1:0] addr_d;
  logic          addr_en;

  // the extra counter bit lets END_ADDR mark the delivered-all state
  assign exhausted = (addr_q == END_ADDR);

  always_comb begin
    addr_en = 1'b0;
    addr_d  = addr_q;
    if (clr) begin
      addr_en = 1'b1;
      addr_d  = '0;
    end else if (adv && !exhausted) begin
      addr_en = 1'b1;
      addr_d  = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

endmodule

// File: rtl/cfg_bit_array.sv
module cfg_bit_array #(
  parameter int DEPTH_BITS = 64,
  parameter int AW         = $clog2(DEPTH_BITS) + 1,
  parameter int IW         = $clog2(DEPTH_BITS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);

  localparam logic [AW-1:0] END_ADDR = AW'(DEPTH_BITS);

  logic mem_q [DEPTH_BITS];

  // one storage cell per bit, each with its own write enable
  for (genvar g = 0; g < DEPTH_BITS; g++) begin : g_cell
    logic cell_we;
    assign cell_we = wr_en && (wr_addr == IW'(g));
    always_ff @(posedge clk) begin
      if (cell_we) mem_q[g] <= wr_bit;
    end
  end

  // out-of-range index (exhausted state) reads as zero
  always_comb begin
    rd_bit = 1'b0;
    if (rd_addr < END_ADDR) rd_bit = mem_q[rd_addr[IW-1:0]];
  end

endmodule

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH_BITS = 64,
  localparam int IW        = $clog2(DEPTH_BITS),
  localparam int AW        = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_oe,
  input  logic          cs_n,
  input  logic          pol_wr_en,
  input  logic          pol_wr_val,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic          wr_bit,
  output logic          data_o,
  output logic          data_oe,
  output logic          cascade_n,
  output logic          chain_first
);

  logic          rst_meta_q, rst_sync_n;
  ctl_t          ctl;
  logic          rst_hit, oe_hit;
  logic [AW-1:0] addr_q;
  logic          exhausted;
  logic          cnt_adv;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cfg_ctrl_decode u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rst_oe      (rst_oe),
    .cs_n        (cs_n),
    .pol_wr_en   (pol_wr_en),
    .pol_wr_val  (pol_wr_val),
    .ctl         (ctl),
    .chain_first (chain_first)
  );

  assign rst_hit = ctl.rst_hit;
  assign oe_hit  = ctl.oe_hit;
  assign cnt_adv = oe_hit && !cs_n;

  cfg_addr_counter #(.DEPTH_BITS(DEPTH_BITS), .AW(AW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (rst_hit),
    .adv       (cnt_adv),
    .addr_q    (addr_q),
    .exhausted (exhausted)
  );

  cfg_bit_array #(.DEPTH_BITS(DEPTH_BITS), .AW(AW), .IW(IW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit  (wr_bit),
    .rd_addr (addr_q),
    .rd_bit  (data_o)
  );

  // drive only while enabled, selected and holding undelivered bits
  assign data_oe   = oe_hit && !cs_n && !exhausted;
  assign cascade_n = !exhausted;

endmodule

// File: rtl/cfg_bit_streamer_chk.sv
module cfg_bit_streamer_chk #(
  parameter int DEPTH_BITS = 64,
  parameter int AW         = $clog2(DEPTH_BITS) + 1
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          cs_n,
  input logic          data_oe,
  input logic          cascade_n,
  input logic          rst_hit,
  input logic          oe_hit,
  input logic [AW-1:0] addr_q
);

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oe_hit && !cs_n && cascade_n) |=> (addr_q == $past(addr_q) + 1'b1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rst_hit && (cs_n || !oe_hit || !cascade_n)) |=> $stable(addr_q));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_hit |=> (addr_q == '0));

  a_r3_float: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_hit |-> !data_oe);

  a_r4_standby: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_n |-> !data_oe);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cascade_n && !rst_hit) |=> !cascade_n);

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cascade_n |-> !data_oe);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    addr_q <= AW'(DEPTH_BITS));

endmodule

bind cfg_bit_streamer cfg_bit_streamer_chk #(.DEPTH_BITS(DEPTH_BITS), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cs_n       (cs_n),
  .data_oe    (data_oe),
  .cascade_n  (cascade_n),
  .rst_hit    (rst_hit),
  .oe_hit     (oe_hit),
  .addr_q     (addr_q)
);

// File: tb/cfg_bit_streamer_tb_top.sv
`timescale 1ns/1ps
module cfg_bit_streamer_tb_top;

  localparam int DEPTH = 16;
  localparam logic [DEPTH-1:0] PAT_A = 16'hB4E1;
  localparam logic [DEPTH-1:0] PAT_B = 16'h6C3A;

  logic clk = 1'b0;
  logic rst_n, rst_oe, cs_n, pol_wr_en, pol_wr_val;
  logic wr_en_a, wr_en_b, wr_bit;
  logic [3:0] wr_addr;
  logic data_a, oe_a, casc_a, first_a;
  logic data_b, oe_b, casc_b, first_b;

  int checks = 0;
  int errors = 0;
  logic mon_on = 1'b0;
  bit exp_q[$];

  always #2 clk = ~clk;

  cfg_bit_streamer #(.DEPTH_BITS(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_oe(rst_oe), .cs_n(cs_n),
    .pol_wr_en(pol_wr_en), .pol_wr_val(pol_wr_val),
    .wr_en(wr_en_a), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .data_o(data_a), .data_oe(oe_a), .cascade_n(casc_a), .chain_first(first_a)
  );

  // second device in the chain: selected by the first one's cascade output
  cfg_bit_streamer #(.DEPTH_BITS(DEPTH)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .rst_oe(rst_oe), .cs_n(casc_a),
    .pol_wr_en(pol_wr_en), .pol_wr_val(pol_wr_val),
    .wr_en(wr_en_b), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .data_o(data_b), .data_oe(oe_b), .cascade_n(casc_b), .chain_first(first_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // inputs change half a nanosecond after a rising edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic load_arrays();
    for (int i = 0; i < DEPTH; i++) begin
      wr_addr = 4'(i); wr_bit = PAT_A[i]; wr_en_a = 1'b1;
      step(1);
    end
    wr_en_a = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      wr_addr = 4'(i); wr_bit = PAT_B[i]; wr_en_b = 1'b1;
      step(1);
    end
    wr_en_b = 1'b0;
  endtask

  // driver side of the scoreboard: expected concatenated stream
  task automatic push_stream();
    for (int i = 0; i < DEPTH; i++) exp_q.push_back(PAT_A[i]);
    for (int i = 0; i < DEPTH; i++) exp_q.push_back(PAT_B[i]);
  endtask

  // monitor: samples at the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      chk("R10 enables overlap", int'(oe_a && oe_b), 0);
      if (oe_a || oe_b) begin
        if (exp_q.size() == 0) begin
          chk("R10 unexpected extra bit", 1, 0);
        end else begin
          chk("R1 R9 stream bit", int'(oe_a ? data_a : data_b), int'(exp_q.pop_front()));
        end
      end
    end
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; rst_oe = 1'b0; cs_n = 1'b0;
    pol_wr_en = 1'b0; pol_wr_val = 1'b0;
    wr_en_a = 1'b0; wr_en_b = 1'b0; wr_bit = 1'b0; wr_addr = '0;
    step(3);
    chk("R7 cascade after reset", int'(casc_a), 1);
    chk("R7 chain flag after reset", int'(first_a), 0);
    rst_n = 1'b1;
    load_arrays();   // rst_oe low = reset level under default polarity
    chk("R8 head device flag", int'(first_a), 1);
    chk("R8 later device flag", int'(first_b), 0);
    chk("R3 no drive in reset A", int'(oe_a), 0);
    chk("R3 no drive in reset B", int'(oe_b), 0);

    // standby then select
    cs_n = 1'b1; rst_oe = 1'b1;
    step(3);
    chk("R4 standby no drive A", int'(oe_a), 0);
    chk("R4 standby no drive B", int'(oe_b), 0);
    cs_n = 1'b0;
    push_stream();
    #0.5;
    chk("R4 drive on select", int'(oe_a), 1);
    chk("R4 frozen at bit 0", int'(data_a), int'(PAT_A[0]));
    mon_on = 1'b1;
    step(32);
    chk("R10 stream fully consumed", exp_q.size(), 0);
    chk("R5 cascade A low", int'(casc_a), 0);
    chk("R5 cascade B low", int'(casc_b), 0);
    step(4);
    chk("R5 cascade stays low", int'(casc_a), 0);
    chk("R5 no drive after end", int'(oe_a || oe_b), 0);

    // reset level clears both
    rst_oe = 1'b0;
    step(1);
    chk("R3 cascade A released", int'(casc_a), 1);
    chk("R3 cascade B released", int'(casc_b), 1);
    chk("R8 flag kept with cs low", int'(first_a), 1);

    // stream with a chip-select pause in the middle
    push_stream();
    rst_oe = 1'b1;
    step(5);
    cs_n = 1'b1;
    #0.5;
    chk("R4 pause no drive", int'(oe_a), 0);
    step(3);
    cs_n = 1'b0;
    step(27);
    chk("R2 resumed stream consumed", exp_q.size(), 0);

    // polarity swap: after the write, low level enables
    rst_oe = 1'b0;
    step(1);
    pol_wr_en = 1'b1; pol_wr_val = 1'b1;
    push_stream();
    step(1);
    pol_wr_en = 1'b0;
    step(32);
    chk("R6 swapped-polarity stream consumed", exp_q.size(), 0);
    rst_oe = 1'b1;
    #0.5;
    chk("R6 high level does not drive", int'(oe_a), 0);
    step(1);
    chk("R6 high level clears counter", int'(casc_a), 1);
    chk("R6 high level still no drive", int'(oe_a), 0);

    // reset with chip select high marks a later device
    cs_n = 1'b1;
    step(1);
    chk("R8 flag cleared with cs high", int'(first_a), 0);
    mon_on = 1'b0;
    report();
  end

endmodule